// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one output compare channel. It follows one of two free-running timer counts, which an input picks. It compares that count against software-written reference values and drives a single output pin. A 3-bit mode field selects the pin behaviour. The behaviours are: disabled, a one-time set or clear on a match, toggle on every match, a single pulse, a repeating pulse train, and PWM. PWM comes in two forms, one that ignores the fault input and one that obeys it. In the guarded PWM mode, a fault forces the pin low and latches a status bit. Software can read this bit but cannot clear it.

Software writes three registers through one write port: control, primary compare (also the PWM duty) and secondary compare. Any write to control restarts the channel in the first state of the new mode. An idle input, together with a freeze bit in control, can stop the channel. The output pin and a one-clock interrupt pulse both come from registers. They change on the clock edge that ends the cycle in which the triggering condition was present.

The state machine has these states:
- ST_OFF.
- ST_SET_WAIT → ST_SET_DONE, on a primary match.
- ST_CLR_WAIT → ST_CLR_DONE, on a primary match.
- ST_TOGGLE, which loops on itself on each primary match.
- ST_ONE_ARM → ST_ONE_HIGH on a primary match, then → ST_ONE_DONE on a secondary match.
- ST_TRN_ARM ⇄ ST_TRN_HIGH: a primary match moves it to high, a secondary match moves it back to arm.
- ST_PWM_FREE, which loops on itself.
- ST_PWM_GUARD → ST_FAULT, on the fault input.

A control write moves the machine from any state to the initial state of the mode just written.

Top module: `oc_channel`

## Requirements
- R1: After reset the control register reads zero, the mode is disabled, and both the output and the interrupt are low.
- R2: Write selector codes are: 0 for control, 1 for primary compare, 2 for secondary compare; 3 is ignored. Control fields are:
  - bits [2:0]: mode.
  - bit 3: timer select.
  - bit 4: fault status. It is read-only, so a write to this bit has no effect.
  - bit 5: idle freeze.
  - all other bits read as zero.
- R3: Every control write restarts the channel on the following edge. Mode 000 drives the output low, mode 010 drives it high and every other mode starts it low. Any pending pulse or fault is discarded.
- R4: In mode 001 the first primary match drives the output high. In mode 010 it drives the output low. Later matches have no effect.
- R5: In mode 011 the output inverts after every cycle in which the selected count equals the primary value.
- R6: Modes 100 and 101 raise the output after a primary match and lower it after the next secondary match. Mode 100 then ignores all matches. Mode 101 re-arms for the next pulse.
- R7: In modes 110 and 111 the output goes high after a cycle in which the selected period strobe is asserted. It goes low after a cycle in which the count equals the active duty. The rollover wins if both occur in the same cycle. The active duty is copied from the primary register on entry to the mode and at each rollover.
- R8: In mode 111, a fault input while running drives the output low and holds it low. It also sets the fault status bit. Both stay until the next control write. Mode 110 ignores the fault input.
- R9: The interrupt is a one-cycle pulse. It fires on each compare-driven output change and on fault entry. It does not fire on a PWM rise or on a control write.
- R10: When timer select is 0 the channel uses timer A, and when it is 1 the channel uses timer B. This applies to both the count and the period strobe.
- R11: When idle is high and the freeze bit is set, no match, rollover, duty load or fault acts, and the output holds. With the freeze bit clear, idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_a_cnt | input | TW | Count of timer A |
| tmr_a_roll | input | 1 | Timer A period strobe (last count of a period) |
| tmr_b_cnt | input | TW | Count of timer B |
| tmr_b_roll | input | 1 | Timer B period strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector |
| wr_data | input | TW | Write data |
| ctl_rdata | output | TW | Control register read value including fault status |
| idle_in | input | 1 | CPU idle indication |
| fault_in | input | 1 | Fault input, active high |
| oc_out | output | 1 | Compare output pin |
| oc_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the channel with TW = 8. Timer A has a period of 20 counts and timer B has a period of 12. A compare value taken from 0 to 19 is therefore reached within a few dozen cycles, so every mode sees many matches and rollovers. A value from 12 to 19 exists only on timer A, which makes the timer select visible at the pin. Timer widths up to 16 bits add no new behaviour, only longer waits between matches.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        MD_OFF  = 3'b000,
        MD_SET  = 3'b001,
        MD_CLR  = 3'b010,
        MD_TGL  = 3'b011,
        MD_ONE  = 3'b100,
        MD_TRN  = 3'b101,
        MD_PWM  = 3'b110,
        MD_PWMF = 3'b111
    } oc_mode_e;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_SET_WAIT,
        ST_SET_DONE,
        ST_CLR_WAIT,
        ST_CLR_DONE,
        ST_TOGGLE,
        ST_ONE_ARM,
        ST_ONE_HIGH,
        ST_ONE_DONE,
        ST_TRN_ARM,
        ST_TRN_HIGH,
        ST_PWM_FREE,
        ST_PWM_GUARD,
        ST_FAULT
    } oc_state_e;

    typedef enum logic [1:0] {
        WS_CTL  = 2'd0,
        WS_PRI  = 2'd1,
        WS_SEC  = 2'd2,
        WS_NONE = 2'd3
    } oc_wsel_e;

    localparam int unsigned CTL_TSEL_BIT = 3;
    localparam int unsigned CTL_FLT_BIT  = 4;
    localparam int unsigned CTL_FRZ_BIT  = 5;
    localparam int unsigned CTL_USED     = 6;

    typedef struct packed {
        logic     frz;
        logic     tsel;
        oc_mode_e mode;
    } oc_ctl_t;

endpackage

// File: rtl/oc_regs.sv
module oc_regs
    import oc_pkg::*;
#(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [TW-1:0] wr_data,
    input  logic          duty_ld,
    input  logic          flt_stat,
    output oc_ctl_t       ctl,
    output logic          ctl_ld,
    output logic [TW-1:0] pri,
    output logic [TW-1:0] sec,
    output logic [TW-1:0] duty,
    output logic [TW-1:0] rdata
);

    logic pri_wr;
    logic sec_wr;

    assign ctl_ld = wr_en && (oc_wsel_e'(wr_sel) == WS_CTL);
    assign pri_wr = wr_en && (oc_wsel_e'(wr_sel) == WS_PRI);
    assign sec_wr = wr_en && (oc_wsel_e'(wr_sel) == WS_SEC);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '{frz: 1'b0, tsel: 1'b0, mode: MD_OFF};
        end else if (ctl_ld) begin
            ctl.frz  <= wr_data[CTL_FRZ_BIT];
            ctl.tsel <= wr_data[CTL_TSEL_BIT];
            ctl.mode <= oc_mode_e'(wr_data[2:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri <= '0;
            sec <= '0;
        end else begin
            if (pri_wr) begin
                pri <= wr_data;
            end
            if (sec_wr) begin
                sec <= wr_data;
            end
        end
    end

    // Active duty: shadow of the primary value, refreshed on mode entry
    // and at each period rollover only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty <= '0;
        end else if (ctl_ld || duty_ld) begin
            duty <= pri;
        end
    end

    always_comb begin
        rdata               = '0;
        rdata[2:0]          = ctl.mode;
        rdata[CTL_TSEL_BIT] = ctl.tsel;
        rdata[CTL_FLT_BIT]  = flt_stat;
        rdata[CTL_FRZ_BIT]  = ctl.frz;
    end

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_ld && !duty_ld) |=> $stable(duty)); // R7

endmodule

// File: rtl/oc_tbsel.sv
module oc_tbsel
    import oc_pkg::*;
#(
    parameter int unsigned TW = 16
) (
    input  logic [TW-1:0] cnt_a,
    input  logic          roll_a,
    input  logic [TW-1:0] cnt_b,
    input  logic          roll_b,
    input  logic          tsel,
    input  logic [TW-1:0] pri,
    input  logic [TW-1:0] sec,
    input  logic [TW-1:0] duty,
    output logic          hit_pri,
    output logic          hit_sec,
    output logic          hit_duty,
    output logic          roll
);

    localparam int unsigned NREF = 3;

    logic [TW-1:0] cnt;
    logic [TW-1:0] refs [NREF];
    logic [NREF-1:0] hits;

    assign cnt  = tsel ? cnt_b : cnt_a;
    assign roll = tsel ? roll_b : roll_a;

    assign refs[0] = pri;
    assign refs[1] = sec;
    assign refs[2] = duty;

    for (genvar g = 0; g < NREF; g++) begin : g_cmp
        assign hits[g] = (cnt == refs[g]);
    end

    assign hit_pri  = hits[0];
    assign hit_sec  = hits[1];
    assign hit_duty = hits[2];

endmodule

// File: rtl/oc_fsm.sv
module oc_fsm
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctl_ld,
    input  oc_mode_e ld_mode,
    input  logic     run,
    input  logic     fault_in,
    input  logic     hit_pri,
    input  logic     hit_sec,
    input  logic     hit_duty,
    input  logic     roll,
    output logic     out_q,
    output logic     irq_q,
    output logic     duty_ld,
    output logic     flt_stat
);

    oc_state_e st;
    oc_state_e st_nx;
    logic      out_nx;
    logic      irq_nx;

    always_comb begin
        st_nx   = st;
        out_nx  = out_q;
        irq_nx  = 1'b0;
        duty_ld = 1'b0;
        if (ctl_ld) begin
            unique case (ld_mode)
                MD_OFF:  begin st_nx = ST_OFF;       out_nx = 1'b0; end
                MD_SET:  begin st_nx = ST_SET_WAIT;  out_nx = 1'b0; end
                MD_CLR:  begin st_nx = ST_CLR_WAIT;  out_nx = 1'b1; end
                MD_TGL:  begin st_nx = ST_TOGGLE;    out_nx = 1'b0; end
                MD_ONE:  begin st_nx = ST_ONE_ARM;   out_nx = 1'b0; end
                MD_TRN:  begin st_nx = ST_TRN_ARM;   out_nx = 1'b0; end
                MD_PWM:  begin st_nx = ST_PWM_FREE;  out_nx = 1'b0; end
                MD_PWMF: begin st_nx = ST_PWM_GUARD; out_nx = 1'b0; end
            endcase
        end else if (run) begin
            unique case (st)
                ST_OFF, ST_SET_DONE, ST_CLR_DONE, ST_ONE_DONE, ST_FAULT: begin
                end
                ST_SET_WAIT: begin
                    if (hit_pri) begin
                        st_nx  = ST_SET_DONE;
                        out_nx = 1'b1;
                        irq_nx = 1'b1;
                    end
                end
                ST_CLR_WAIT: begin
                    if (hit_pri) begin
                        st_nx  = ST_CLR_DONE;
                        out_nx = 1'b0;
                        irq_nx = 1'b1;
                    end
                end
                ST_TOGGLE: begin
                    if (hit_pri) begin
                        out_nx = !out_q;
                        irq_nx = 1'b1;
                    end
                end
                ST_ONE_ARM: begin
                    if (hit_pri) begin
                        st_nx  = ST_ONE_HIGH;
                        out_nx = 1'b1;
                        irq_nx = 1'b1;
                    end
                end
                ST_ONE_HIGH: begin
                    if (hit_sec) begin
                        st_nx  = ST_ONE_DONE;
                        out_nx = 1'b0;
                        irq_nx = 1'b1;
                    end
                end
                ST_TRN_ARM: begin
                    if (hit_pri) begin
                        st_nx  = ST_TRN_HIGH;
                        out_nx = 1'b1;
                        irq_nx = 1'b1;
                    end
                end
                ST_TRN_HIGH: begin
                    if (hit_sec) begin
                        st_nx  = ST_TRN_ARM;
                        out_nx = 1'b0;
                        irq_nx = 1'b1;
                    end
                end
                ST_PWM_FREE, ST_PWM_GUARD: begin
                    if ((st == ST_PWM_GUARD) && fault_in) begin
                        st_nx  = ST_FAULT;
                        out_nx = 1'b0;
                        irq_nx = 1'b1;
                    end else if (roll) begin
                        out_nx  = 1'b1;
                        duty_ld = 1'b1;
                    end else if (hit_duty && out_q) begin
                        out_nx = 1'b0;
                        irq_nx = 1'b1;
                    end
                end
                default: begin
                    st_nx  = ST_OFF;
                    out_nx = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_OFF;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            out_q <= out_nx;
            irq_q <= irq_nx;
        end
    end

    assign flt_stat = (st == ST_FAULT);

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) |-> !out_q); // R3

    AST_FAULT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAULT) |-> !out_q); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_ONE_DONE) && !ctl_ld) |=> (st == ST_ONE_DONE)); // R6

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ((out_q != $past(out_q)) || flt_stat)); // R9

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctl_ld) |=> $stable(out_q)); // R11

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tmr_a_cnt,
    input  logic          tmr_a_roll,
    input  logic [TW-1:0] tmr_b_cnt,
    input  logic          tmr_b_roll,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [TW-1:0] wr_data,
    output logic [TW-1:0] ctl_rdata,
    input  logic          idle_in,
    input  logic          fault_in,
    output logic          oc_out,
    output logic          oc_irq
);

    oc_ctl_t       ctl;
    logic          ctl_ld;
    logic [TW-1:0] pri;
    logic [TW-1:0] sec;
    logic [TW-1:0] duty;
    logic          duty_ld;
    logic          flt_stat;
    logic          hit_pri;
    logic          hit_sec;
    logic          hit_duty;
    logic          roll;
    logic          run;

    assign run = !(idle_in && ctl.frz);

    oc_regs #(.TW(TW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .duty_ld  (duty_ld),
        .flt_stat (flt_stat),
        .ctl      (ctl),
        .ctl_ld   (ctl_ld),
        .pri      (pri),
        .sec      (sec),
        .duty     (duty),
        .rdata    (ctl_rdata)
    );

    oc_tbsel #(.TW(TW)) u_tbsel (
        .cnt_a    (tmr_a_cnt),
        .roll_a   (tmr_a_roll),
        .cnt_b    (tmr_b_cnt),
        .roll_b   (tmr_b_roll),
        .tsel     (ctl.tsel),
        .pri      (pri),
        .sec      (sec),
        .duty     (duty),
        .hit_pri  (hit_pri),
        .hit_sec  (hit_sec),
        .hit_duty (hit_duty),
        .roll     (roll)
    );

    oc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_ld   (ctl_ld),
        .ld_mode  (oc_mode_e'(wr_data[2:0])),
        .run      (run),
        .fault_in (fault_in),
        .hit_pri  (hit_pri),
        .hit_sec  (hit_sec),
        .hit_duty (hit_duty),
        .roll     (roll),
        .out_q    (oc_out),
        .irq_q    (oc_irq),
        .duty_ld  (duty_ld),
        .flt_stat (flt_stat)
    );

    AST_MODE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ld |=> (ctl.mode == oc_mode_e'($past(wr_data[2:0])))); // R2

endmodule

// File: tb/sim_oc_channel.sv
`timescale 1ns/1ps
module sim_oc_channel;

    localparam int TW = 8;
    localparam int PA = 19;
    localparam int PB = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [TW-1:0] ca, cb;
    logic          ra, rb;
    logic          wr_en;
    logic [1:0]    wr_sel;
    logic [TW-1:0] wr_data;
    logic [TW-1:0] rd;
    logic          idle, flt;
    logic          o, irq;

    int n_chk = 0;
    int n_bad = 0;

    int       m_mode, m_phase;
    logic     m_tsel, m_frz, m_flt, m_out, m_irq;
    logic [TW-1:0] m_pri, m_sec, m_duty;

    always #4 clk = ~clk;

    oc_channel #(.TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tmr_a_cnt(ca), .tmr_a_roll(ra),
        .tmr_b_cnt(cb), .tmr_b_roll(rb),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctl_rdata(rd), .idle_in(idle), .fault_in(flt),
        .oc_out(o), .oc_irq(irq)
    );

    function automatic string req_of(int md);
        case (md)
            0:       return "R3";
            1, 2:    return "R4";
            3:       return "R5";
            4, 5:    return "R6";
            6:       return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [TW-1:0] exp_rd();
        logic [TW-1:0] v;
        v = '0;
        v[2:0] = m_mode[2:0];
        v[3] = m_tsel;
        v[4] = m_flt;
        v[5] = m_frz;
        return v;
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [TW-1:0] c;
        logic r, run;
        c   = m_tsel ? cb : ca;
        r   = m_tsel ? rb : ra;
        run = !(idle && m_frz);
        m_irq = 1'b0;
        if (wr_en && wr_sel == 2'd0) begin
            m_mode  = int'(wr_data[2:0]);
            m_tsel  = wr_data[3];
            m_frz   = wr_data[5];
            m_flt   = 1'b0;
            m_phase = 0;
            m_duty  = m_pri;
            m_out   = (m_mode == 2);
        end else begin
            if (run) begin
                case (m_mode)
                    1, 2: if (m_phase == 0 && c == m_pri) begin
                        m_out = (m_mode == 1); m_phase = 1; m_irq = 1'b1;
                    end
                    3: if (c == m_pri) begin
                        m_out = !m_out; m_irq = 1'b1;
                    end
                    4, 5: begin
                        if (m_phase == 0 && c == m_pri) begin
                            m_out = 1'b1; m_phase = 1; m_irq = 1'b1;
                        end else if (m_phase == 1 && c == m_sec) begin
                            m_out = 1'b0; m_phase = (m_mode == 4) ? 2 : 0; m_irq = 1'b1;
                        end
                    end
                    6, 7: begin
                        if (!m_flt) begin
                            if (m_mode == 7 && flt) begin
                                m_flt = 1'b1; m_out = 1'b0; m_irq = 1'b1;
                            end else if (r) begin
                                m_out = 1'b1; m_duty = m_pri;
                            end else if (c == m_duty && m_out) begin
                                m_out = 1'b0; m_irq = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (wr_en && wr_sel == 2'd1) m_pri = wr_data;
            if (wr_en && wr_sel == 2'd2) m_sec = wr_data;
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        chk(o === m_out, req_of(m_mode), "oc_out", int'(o), int'(m_out));
        chk(irq === m_irq, "R9", "oc_irq", int'(irq), int'(m_irq));
        chk(rd === exp_rd(), "R2", "ctl_rdata", int'(rd), int'(exp_rd()));
        wr_en  = 1'b0;
        wr_sel = 2'd3;
        ca = (ca == PA) ? '0 : ca + 1'b1;
        cb = (cb == PB) ? '0 : cb + 1'b1;
        ra = (ca == PA);
        rb = (cb == PB);
    endtask

    task automatic wr(input int sel, input int d);
        wr_en   = 1'b1;
        wr_sel  = sel[1:0];
        wr_data = d[TW-1:0];
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int rises;
        logic prev;
        void'($urandom(32'd4242));
        rst_n = 1'b0; ca = '0; cb = '0; ra = 1'b0; rb = 1'b0;
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0; idle = 1'b0; flt = 1'b0;
        m_mode = 0; m_phase = 0; m_tsel = 0; m_frz = 0; m_flt = 0;
        m_out = 0; m_irq = 0; m_pri = '0; m_sec = '0; m_duty = '0;
        repeat (4) @(posedge clk);
        #1;
        chk(o == 1'b0, "R1", "reset out", int'(o), 0);
        chk(irq == 1'b0, "R1", "reset irq", int'(irq), 0);
        chk(rd == '0, "R1", "reset ctl", int'(rd), 0);
        rst_n = 1'b1;

        // R2: fault bit and upper bits not writable
        wr(0, 8'hFF);
        chk(rd == 8'h2F, "R2", "ctl readback", int'(rd), 8'h2F);
        wr(0, 8'h00);

        // R10: value 15 exists only on timer A
        wr(1, 15);
        wr(0, 8'h09);
        repeat (40) tick();
        chk(o == 1'b0, "R10", "timer B selected", int'(o), 0);
        wr(0, 8'h01);
        repeat (40) tick();
        chk(o == 1'b1, "R10", "timer A selected", int'(o), 1);

        // R3: restart levels
        wr(0, 8'h00);
        chk(o == 1'b0, "R3", "off drives low", int'(o), 0);
        wr(0, 8'h02);
        chk(o == 1'b1, "R3", "mode 010 starts high", int'(o), 1);

        // R6: single pulse then continuous pulses
        wr(1, 3); wr(2, 6); wr(0, 8'h04);
        rises = 0;
        repeat (80) begin prev = o; tick(); if (o && !prev) rises++; end
        chk(rises == 1, "R6", "single pulse count", rises, 1);
        wr(0, 8'h05);
        rises = 0;
        repeat (80) begin prev = o; tick(); if (o && !prev) rises++; end
        chk(rises >= 3, "R6", "pulse train count", rises, 4);

        // R7: duty change waits for the rollover
        wr(1, 5); wr(0, 8'h06);
        while (!ra) tick();
        tick();
        while (ca != 2) tick();
        wr(1, 12);
        while (ca != 7) tick();
        chk(o == 1'b0, "R7", "old duty in force", int'(o), 0);
        tick();
        while (ca != 7) tick();
        chk(o == 1'b1, "R7", "new duty after rollover", int'(o), 1);

        // R8/R9: fault latch in guarded PWM
        wr(0, 8'h07);
        while (!ra) tick();
        tick();
        flt = 1'b1;
        tick();
        flt = 1'b0;
        chk(irq == 1'b1, "R9", "fault irq", int'(irq), 1);
        chk(rd[4] == 1'b1, "R8", "fault status set", int'(rd[4]), 1);
        repeat (30) tick();
        chk(o == 1'b0, "R8", "fault holds low", int'(o), 0);
        chk(rd[4] == 1'b1, "R8", "fault status held", int'(rd[4]), 1);
        wr(0, 8'h07);
        chk(rd[4] == 1'b0, "R8", "fault cleared by rewrite", int'(rd[4]), 0);

        // R8: free PWM ignores the fault
        wr(0, 8'h06);
        while (!ra) tick();
        tick();
        flt = 1'b1;
        tick();
        flt = 1'b0;
        chk(o == 1'b1, "R8", "mode 110 ignores fault", int'(o), 1);
        chk(rd[4] == 1'b0, "R8", "no status in 110", int'(rd[4]), 0);

        // R11: freeze in idle, then no freeze
        wr(1, 4); wr(0, 8'h23);
        idle = 1'b1;
        prev = o;
        rises = 0;
        repeat (45) begin tick(); if (irq) rises++; end
        chk(o == prev, "R11", "frozen output", int'(o), int'(prev));
        chk(rises == 0, "R11", "frozen events", rises, 0);
        wr(0, 8'h03);
        rises = 0;
        repeat (45) begin tick(); if (irq) rises++; end
        chk(rises > 0, "R11", "idle without freeze runs", rises, 2);
        idle = 1'b0;

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            idle = (($urandom % 5) == 0);
            flt  = (($urandom % 25) == 0);
            if (($urandom % 30) == 0) begin
                int s;
                s = int'($urandom % 4);
                if (s == 0) wr(0, int'($urandom % 256));
                else        wr(s, int'($urandom % 20));
            end else begin
                tick();
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule